// File: doc/BRIEF.md
# Serial Configuration Load Sequencer

This block sits on the host side of a programmable device and runs a bit-serial configuration load into it. A restart request pulls the device's program request low for a programmable minimum time. The block then waits for the device to finish clearing its configuration memory, which the device shows by pulling its open-drain init line low and then releasing it. After that the block turns an upstream byte stream into one data bit per configuration clock.

When the final byte has been shifted, the sequencer keeps the configuration clock running so that the device can go through its start-up phase. It watches two outcomes. Done rising means the load succeeded. Init dropping at any point after shifting has begun means the device found a CRC error. If done never rises, a cycle counter ends the wait and reports its own failure code. The mode strap pins are a constant selected by a parameter.

Top module: `cfg_serial_loader`

## Requirements
- R1: After synchronous reset, the outputs are: program request high (inactive), configuration clock low, busy low, pass low, fail low, fail code 0, and upstream ready low.
- R2: A restart pulse, sampled on a clock edge, drives the program request low starting at that edge. The request stays low for exactly PROG_MIN clock cycles, and busy is high from that edge onward.
- R3: No configuration clock edge occurs and upstream ready stays low until init has been seen low and then high again, after the synchronizer delay.
- R4: Each byte is sent most significant bit first. A bit lasts two system clocks: one with the configuration clock low, then one with it high. The data output changes only while the configuration clock is low.
- R5: Bytes are accepted when valid and ready are both high, and they are sent in the order accepted. A byte offered back to back continues at the same two-clock bit pace. While no byte is offered, the configuration clock stays low and ready stays high.
- R6: If init reads low after shifting has begun, whether during shifting or during the post-load clocks, the block stops the clock and reports fail high, busy low and fail code 1 (CRC error).
- R7: After the byte flagged last, the configuration clock keeps toggling. When done reads high, the block reports pass high, busy low and fail low, and stops the clock.
- R8: If done has not risen within DONE_WAIT cycles after the last bit, the block reports fail high with fail code 2 (timeout).
- R9: The mode strap output is constant: 3'b000 when MODE_ALT is 0, and 3'b100 when MODE_ALT is 1.
- R10: A restart in any state, including partway through a load, abandons the load at once. It drives the program request low and clears pass and fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Start or restart a configuration load |
| s_valid_i | input | 1 | Upstream byte valid |
| s_data_i | input | 8 | Upstream bitstream byte |
| s_last_i | input | 1 | Marks the final byte of the bitstream |
| s_ready_o | output | 1 | Upstream byte accepted when high with valid |
| prog_n_o | output | 1 | Program request to the device, active low |
| cclk_o | output | 1 | Configuration clock |
| dout_o | output | 1 | Serial configuration data |
| init_i | input | 1 | Device init status line (open-drain, asynchronous) |
| done_i | input | 1 | Device done status line (asynchronous) |
| mode_o | output | 3 | Static mode strap code |
| busy_o | output | 1 | Load sequence in progress |
| pass_o | output | 1 | Load finished with done high |
| fail_o | output | 1 | Load finished with an error |
| fail_code_o | output | 2 | 0 none, 1 CRC error, 2 done timeout |

## Verification
The serial path is driven three ways. A continuous three-byte stream with alternating, nibble-swapped and all-ones patterns shows whether bit order and bit pace survive the byte boundaries. A stream with a long pause between two bytes shows whether the block stalls the clock low rather than sending stale bits. A single-byte load checks the post-load clock on its own. The status lines are driven on separate runs: done rising (pass), init dropping partway through a byte (CRC), done never rising (timeout), and a restart in mid-load. These runs tell apart the three endings and the abort path, and show that the load does not begin until the device has finished clearing.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_SHIFT,
        ST_FLUSH,
        ST_PASS,
        ST_FAIL
    } cfgld_state_e;

    typedef enum logic [1:0] {
        FAIL_NONE    = 2'd0,
        FAIL_CRC     = 2'd1,
        FAIL_TIMEOUT = 2'd2
    } cfgld_fail_e;

    typedef struct packed {
        logic prog_n;
        logic run_shift;
        logic run_free;
        logic busy;
        logic pass;
        logic fail;
    } cfgld_ctl_t;

    function automatic logic [2:0] strap_code(input bit alt);
        return alt ? 3'b100 : 3'b000;
    endfunction

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_shift_i,
    input  logic              run_free_i,
    input  logic              s_valid_i,
    input  logic [BYTE_W-1:0] s_data_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    output logic              dout_o,
    output logic              cclk_o,
    output logic              last_sent_o
);
    logic [BYTE_W-1:0]    sreg;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic                 have;
    logic                 is_last;
    logic                 phase;
    logic                 end_of_byte;
    logic                 take;

    assign end_of_byte = have && phase && (bit_idx == BIT_IDX_W'(BYTE_W - 1));
    assign s_ready_o   = run_shift_i && (!have || (end_of_byte && !is_last));
    assign take        = s_ready_o && s_valid_i;
    assign last_sent_o = run_shift_i && end_of_byte && is_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            bit_idx <= '0;
            have    <= 1'b0;
            is_last <= 1'b0;
            phase   <= 1'b0;
        end else if (!(run_shift_i || run_free_i)) begin
            bit_idx <= '0;
            have    <= 1'b0;
            is_last <= 1'b0;
            phase   <= 1'b0;
        end else if (run_free_i) begin
            phase <= ~phase;
        end else if (take) begin
            sreg    <= s_data_i;
            is_last <= s_last_i;
            have    <= 1'b1;
            bit_idx <= '0;
            phase   <= 1'b0;
        end else if (have) begin
            phase <= ~phase;
            if (phase) begin
                if (bit_idx == BIT_IDX_W'(BYTE_W - 1)) begin
                    have <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    sreg    <= {sreg[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign dout_o = sreg[BYTE_W-1];
    assign cclk_o = phase && (run_shift_i || run_free_i);

    // R4: data may only move while the configuration clock is low
    assert_data_steady_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout_o) |-> !cclk_o);

    // R4: every high half-bit lasts exactly one system clock
    assert_half_bit_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cclk_o) |=> !cclk_o);

    // R5: a newly accepted byte always starts with the clock low
    assert_accept_low_R5: assert property (@(posedge clk) disable iff (rst)
        (s_valid_i && s_ready_o) |=> !cclk_o);
endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
    import cfgld_pkg::*;
#(
    parameter int PROG_MIN  = 16,
    parameter int DONE_WAIT = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart_i,
    input  logic        init_s_i,
    input  logic        done_s_i,
    input  logic        last_sent_i,
    output cfgld_ctl_t  ctl_o,
    output logic [1:0]  fail_code_o
);
    localparam int CNT_MAX = (PROG_MIN > DONE_WAIT) ? PROG_MIN : DONE_WAIT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    cfgld_state_e     state;
    cfgld_fail_e      code;
    logic [CNT_W-1:0] cnt;
    logic             seen_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            code     <= FAIL_NONE;
            cnt      <= '0;
            seen_low <= 1'b0;
        end else if (restart_i) begin
            state    <= ST_PROG;
            code     <= FAIL_NONE;
            cnt      <= '0;
            seen_low <= 1'b0;
        end else begin
            case (state)
                ST_PROG: begin
                    if (!init_s_i) seen_low <= 1'b1;
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(PROG_MIN - 1)) begin
                        state <= ST_WAIT_INIT;
                    end
                end
                ST_WAIT_INIT: begin
                    if (!init_s_i) begin
                        seen_low <= 1'b1;
                    end else if (seen_low) begin
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (!init_s_i) begin
                        state <= ST_FAIL;
                        code  <= FAIL_CRC;
                    end else if (last_sent_i) begin
                        state <= ST_FLUSH;
                        cnt   <= '0;
                    end
                end
                ST_FLUSH: begin
                    if (!init_s_i) begin
                        state <= ST_FAIL;
                        code  <= FAIL_CRC;
                    end else if (done_s_i) begin
                        state <= ST_PASS;
                    end else if (cnt == CNT_W'(DONE_WAIT - 1)) begin
                        state <= ST_FAIL;
                        code  <= FAIL_TIMEOUT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ctl_o.prog_n    = (state != ST_PROG);
        ctl_o.run_shift = (state == ST_SHIFT);
        ctl_o.run_free  = (state == ST_FLUSH);
        ctl_o.busy      = state inside {ST_PROG, ST_WAIT_INIT, ST_SHIFT, ST_FLUSH};
        ctl_o.pass      = (state == ST_PASS);
        ctl_o.fail      = (state == ST_FAIL);
    end

    assign fail_code_o = code;

    // R2: program request held for the full minimum width
    assert_prog_width_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG && cnt < CNT_W'(PROG_MIN - 1) && !restart_i) |=> (state == ST_PROG));

    // R3: shifting never starts before init has been seen low
    assert_wait_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_INIT && !seen_low && !restart_i) |=> (state != ST_SHIFT));

    // R6: init low after shifting began is a CRC failure
    assert_crc_fail_R6: assert property (@(posedge clk) disable iff (rst)
        (state inside {ST_SHIFT, ST_FLUSH} && !init_s_i && !restart_i)
        |=> (state == ST_FAIL && code == FAIL_CRC));

    // R8: the post-load wait ends with the timeout code
    assert_timeout_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLUSH && init_s_i && !done_s_i && !restart_i && cnt == CNT_W'(DONE_WAIT - 1))
        |=> (state == ST_FAIL && code == FAIL_TIMEOUT));

    // R7: a passing load carries no failure code
    assert_pass_clean_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASS) |-> (code == FAIL_NONE));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgld_pkg::*;
#(
    parameter int PROG_MIN    = 16,
    parameter int DONE_WAIT   = 1000,
    parameter int SYNC_STAGES = 2,
    parameter bit MODE_ALT    = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart_i,
    input  logic        s_valid_i,
    input  logic [7:0]  s_data_i,
    input  logic        s_last_i,
    output logic        s_ready_o,
    output logic        prog_n_o,
    output logic        cclk_o,
    output logic        dout_o,
    input  logic        init_i,
    input  logic        done_i,
    output logic [2:0]  mode_o,
    output logic        busy_o,
    output logic        pass_o,
    output logic        fail_o,
    output logic [1:0]  fail_code_o
);
    cfgld_ctl_t ctl;
    logic       init_s;
    logic       done_s;
    logic       last_sent;

    cfgld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_init_sync (
        .clk(clk), .rst(rst), .d_i(init_i), .q_o(init_s)
    );

    cfgld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
        .clk(clk), .rst(rst), .d_i(done_i), .q_o(done_s)
    );

    cfgld_ctrl #(.PROG_MIN(PROG_MIN), .DONE_WAIT(DONE_WAIT)) u_ctrl (
        .clk(clk), .rst(rst), .restart_i(restart_i),
        .init_s_i(init_s), .done_s_i(done_s), .last_sent_i(last_sent),
        .ctl_o(ctl), .fail_code_o(fail_code_o)
    );

    cfgld_shift u_shift (
        .clk(clk), .rst(rst),
        .run_shift_i(ctl.run_shift), .run_free_i(ctl.run_free),
        .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i),
        .s_ready_o(s_ready_o), .dout_o(dout_o), .cclk_o(cclk_o),
        .last_sent_o(last_sent)
    );

    generate
        if (MODE_ALT) begin : g_strap_alt
            assign mode_o = strap_code(1'b1);
        end else begin : g_strap_base
            assign mode_o = strap_code(1'b0);
        end
    endgenerate

    assign prog_n_o = ctl.prog_n;
    assign busy_o   = ctl.busy;
    assign pass_o   = ctl.pass;
    assign fail_o   = ctl.fail;

    // R10: restart takes effect on the next edge
    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (!prog_n_o && busy_o && !pass_o && !fail_o));

    // R3: the clock is quiet whenever no load is running
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!cclk_o && !s_ready_o));

    // R6: a failed load always names a cause
    assert_fail_coded_R6: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (fail_code_o != 2'd0));
endmodule

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_MIN   = 4;
    localparam int DONE_WAIT  = 40;
    localparam int CLEAR_CYC  = 20;
    localparam int WD_LIMIT   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       restart = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0;
    logic       s_ready, prog_n, cclk, dout, busy, pass, fail;
    logic [2:0] mode;
    logic [1:0] fcode;
    logic       dev_init = 1'b1;
    logic       dev_done = 1'b0;
    logic       dev_crc = 1'b0;
    int         clear_left = 0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rises = 0;
    int flush_rises = 0;
    int last_rise = -1;
    bit chk_gap = 1'b0;
    bit prev_cclk = 1'b0;
    bit exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_serial_loader #(
        .PROG_MIN(PROG_MIN), .DONE_WAIT(DONE_WAIT), .SYNC_STAGES(2), .MODE_ALT(1'b0)
    ) dut_i (
        .clk(clk), .rst(rst), .restart_i(restart),
        .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
        .prog_n_o(prog_n), .cclk_o(cclk), .dout_o(dout),
        .init_i(dev_init), .done_i(dev_done), .mode_o(mode),
        .busy_o(busy), .pass_o(pass), .fail_o(fail), .fail_code_o(fcode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // device model: init low while program is low and during clearing
    always @(negedge clk) begin
        if (!prog_n) begin
            dev_init   <= 1'b0;
            clear_left <= CLEAR_CYC;
        end else if (dev_crc) begin
            dev_init <= 1'b0;
        end else if (clear_left > 0) begin
            clear_left <= clear_left - 1;
        end else begin
            dev_init <= 1'b1;
        end
    end

    // monitor: scoreboard of serial bits, sampled at rising configuration clock
    always @(negedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            check(1'b0, "watchdog", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (!rst && cclk && !prev_cclk) begin
            rises++;
            if (exp_q.size() > 0) begin
                bit b;
                b = exp_q.pop_front();
                check(dout == b, "R4 serial bit", int'(dout), int'(b));
                if (chk_gap && last_rise >= 0)
                    check(cyc - last_rise == 2, "R5 bit pace", cyc - last_rise, 2);
                last_rise = cyc;
            end else begin
                flush_rises++;
            end
        end
        prev_cclk = cclk;
    end

    task automatic send_one(input logic [7:0] d, input bit last, input bit hold);
        s_valid = 1'b1;
        s_data  = d;
        s_last  = last;
        while (!s_ready) @(negedge clk);
        for (int i = 7; i >= 0; i--) exp_q.push_back(d[i]);
        @(negedge clk);
        if (!hold) s_valid = 1'b0;
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic wait_drained();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        int n;
        int base;
        wait_cyc(3);
        // R1 reset state
        check(prog_n == 1'b1, "R1 prog_n", int'(prog_n), 1);
        check(cclk == 1'b0 && busy == 1'b0, "R1 cclk/busy", int'({cclk, busy}), 0);
        check(pass == 1'b0 && fail == 1'b0 && fcode == 2'd0, "R1 status", int'({pass, fail, fcode}), 0);
        check(s_ready == 1'b0, "R1 ready", int'(s_ready), 0);
        check(mode == 3'b000, "R9 strap", int'(mode), 0);
        @(negedge clk);
        rst = 1'b0;
        wait_cyc(2);

        // R2 program pulse width
        do_restart();
        check(busy == 1'b1, "R2 busy", int'(busy), 1);
        n = 0;
        while (!prog_n) begin n++; @(negedge clk); end
        check(n == PROG_MIN, "R2 prog width", n, PROG_MIN);

        // R3/R4/R5: back-to-back stream, gated on init release
        base = rises;
        chk_gap = 1'b1;
        last_rise = -1;
        fork
            begin
                send_one(8'hA5, 1'b0, 1'b1);
                send_one(8'h3C, 1'b0, 1'b1);
                send_one(8'hFF, 1'b1, 1'b0);
            end
            begin
                wait_cyc(12);
                check(rises == base, "R3 no clock before init", rises - base, 0);
                check(s_ready == 1'b0, "R3 ready held", int'(s_ready), 0);
            end
        join
        wait_drained();
        chk_gap = 1'b0;
        check(rises - base == 24, "R5 bit count", rises - base, 24);

        // R7 pass
        base = flush_rises;
        wait_cyc(6);
        check(flush_rises > base, "R7 post-load clocks", flush_rises - base, 1);
        dev_done = 1'b1;
        wait_cyc(5);
        check(pass == 1'b1 && busy == 1'b0 && fail == 1'b0, "R7 pass", int'({pass, busy, fail}), 4);
        check(cclk == 1'b0, "R7 clock stopped", int'(cclk), 0);
        dev_done = 1'b0;

        // R5 stall with a gap between bytes
        do_restart();
        wait_cyc(PROG_MIN);
        send_one(8'h81, 1'b0, 1'b0);
        wait_cyc(30);
        check(exp_q.size() == 0, "R5 first byte sent", exp_q.size(), 0);
        check(cclk == 1'b0 && s_ready == 1'b1, "R5 stall", int'({cclk, s_ready}), 1);
        base = rises;
        wait_cyc(4);
        check(rises == base, "R5 no clock in gap", rises - base, 0);
        send_one(8'h5A, 1'b1, 1'b0);
        wait_drained();
        wait_cyc(4);
        dev_done = 1'b1;
        wait_cyc(5);
        check(pass == 1'b1, "R7 pass after gap", int'(pass), 1);
        dev_done = 1'b0;

        // R6 CRC failure partway through a byte
        do_restart();
        wait_cyc(PROG_MIN);
        send_one(8'hC3, 1'b0, 1'b1);
        send_one(8'h0F, 1'b1, 1'b0);
        wait_cyc(4);
        dev_crc = 1'b1;
        wait_cyc(6);
        check(fail == 1'b1 && busy == 1'b0, "R6 fail", int'({fail, busy}), 2);
        check(fcode == 2'd1, "R6 crc code", int'(fcode), 1);
        exp_q.delete();
        base = rises;
        wait_cyc(10);
        check(rises == base, "R6 clock stopped", rises - base, 0);
        dev_crc = 1'b0;

        // R8 timeout with done never rising
        do_restart();
        wait_cyc(PROG_MIN);
        send_one(8'h96, 1'b1, 1'b0);
        wait_drained();
        wait_cyc(DONE_WAIT / 2);
        check(fail == 1'b0 && busy == 1'b1, "R8 still waiting", int'({fail, busy}), 1);
        wait_cyc(DONE_WAIT);
        check(fail == 1'b1 && fcode == 2'd2, "R8 timeout code", int'(fcode), 2);

        // R10 restart in mid-load
        do_restart();
        wait_cyc(PROG_MIN);
        send_one(8'hE7, 1'b0, 1'b1);
        send_one(8'h18, 1'b1, 1'b0);
        wait_cyc(3);
        do_restart();
        exp_q.delete();
        check(prog_n == 1'b0 && busy == 1'b1, "R10 restart", int'({prog_n, busy}), 1);
        check(pass == 1'b0 && fail == 1'b0, "R10 status clear", int'({pass, fail}), 0);
        check(mode == 3'b000, "R9 strap steady", int'(mode), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule